// File: doc/BRIEF.md
# Power-of-Two Input Debounce Filter

This block cleans up slow, bouncy input pins before the rest of the chip sees them. Every lane takes one raw pin level, brings it into the clock domain through a short synchronizer chain, and then holds its filtered output until the new level has stayed put for a programmed settle time. One shared prescaler turns the system clock into a millisecond tick. Every lane counts those ticks on its own.

Each lane is programmed with a 4-bit slice of its pin control word. The slice holds a debounce enable and a 3-bit exponent `n`, which selects a settle time of 2^n milliseconds, from 1 ms to 128 ms. The surrounding register logic passes bits 8..5 of the pin's control word into this slice, so the enable sits above the exponent. With the enable clear, the lane does no filtering and the synchronized level appears at the output directly. When reset is released, each lane loads its current input level straight away, so a pin that is already steady does not wait one full settle time.

Top module: `pow2_debounce`

## Requirements
- R1: Each lane's 4-bit field holds the enable in bit 3 and the exponent n in bits 2:0. The settle time is 2^n milliseconds, and one millisecond is CLKS_PER_MS clock cycles of the shared tick.
- R2: With the enable clear, the lane output equals the raw input delayed by exactly SYNC_STAGES rising clock edges.
- R3: With the enable set, a new level held on the raw input appears at the output no later than SYNC_STAGES + 1 + 2^n·CLKS_PER_MS rising edges after the raw change.
- R4: With the enable set, the output still shows the old level SYNC_STAGES + 1 + (2^n − 1)·CLKS_PER_MS rising edges after the raw change.
- R5: A pulse away from the current output level that lasts at most (2^n − 1)·CLKS_PER_MS cycles leaves the output unchanged.
- R6: Any return of the synchronized input to the output level, or any further change, restarts the count. A train of such pulses separated by single cycles at the old level never commits, however long the train lasts.
- R7: While enabled and past the post-reset load, the output changes only on a cycle that follows a millisecond tick, and only to the current synchronized level.
- R8: During reset every output is 0. After reset is released, with the raw input steady, each output equals the raw level within SYNC_STAGES + 2 edges, whatever the programmed settle time.
- R9: Lanes are independent. A change of input or field on one lane never moves another lane's output.
- R10: Exponent 0 gives a settle time of one millisecond, and exponent 7 gives 128 milliseconds, both within the R3/R4 bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | LANES*4 | Per-lane field {enable, exponent[2:0]}, lane 0 in the low nibble |
| raw_i | input | LANES | Raw asynchronous pin levels |
| filt_o | output | LANES | Debounced (or bypassed) pin levels |

## Verification
The assertions assume that a lane's field does not shrink its exponent in the middle of a count in a way that later matters. They also assume that the field is changed only while the lane's synchronized input matches its output. The stimulus meets both conditions, because it reprograms a lane only after that lane has settled. The raw inputs are driven on the falling clock edge, so the synchronizer never sees a value that changes at the sampling edge. Random pulse lengths are drawn only up to the R5 bound, so every glitch that should be rejected really is shorter than the settle window.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    localparam int EXP_W   = 3;
    localparam int FIELD_W = EXP_W + 1;
    localparam int LIM_W   = 2 ** EXP_W;

    typedef struct packed {
        logic             enable;
        logic [EXP_W-1:0] expo;
    } dbf_field_t;
endpackage

// File: rtl/dbf_tick.sv
module dbf_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + CW'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // independent gap counter to check tick spacing
    logic [CW:0] gap_d, gap_q;
    assign gap_d = tick_o ? (CW+1)'(1) : gap_q + (CW+1)'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gap_q <= '0;
        else         gap_q <= gap_d;
    end

    a_r1_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (gap_q == (CW+1)'(CLKS_PER_MS)));
endmodule

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dbf_lane.sv
module dbf_lane
    import dbf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               raw_i,
    output logic               filt_o
);
    localparam int PRIME_W = $clog2(SYNC_STAGES + 2);
    localparam logic [PRIME_W-1:0] PRIME_DONE = PRIME_W'(SYNC_STAGES + 1);

    typedef struct packed {
        logic               out;
        logic               last;
        logic [LIM_W-1:0]   cnt;
        logic [PRIME_W-1:0] prime;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    dbf_field_t       cfg;
    logic             sync_w;
    logic             primed_w;
    logic [LIM_W-1:0] limit_w;

    dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_i),
        .q_o    (sync_w)
    );

    assign cfg      = dbf_field_t'(field_i);
    assign primed_w = (st_q.prime == PRIME_DONE);
    assign limit_w  = LIM_W'(1) << cfg.expo;

    always_comb begin
        st_d      = st_q;
        st_d.last = sync_w;
        if (!primed_w) st_d.prime = st_q.prime + PRIME_W'(1);

        if (!primed_w || !cfg.enable) begin
            st_d.out = sync_w;
            st_d.cnt = '0;
        end else if ((sync_w == st_q.out) || (sync_w != st_q.last)) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if ((st_q.cnt + LIM_W'(1)) >= limit_w) begin
                st_d.out = sync_w;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign filt_o = (primed_w && cfg.enable) ? st_q.out : sync_w;

    a_r7_commit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_w && $past(primed_w) && cfg.enable && $past(cfg.enable)
         && (st_q.out != $past(st_q.out))) |-> $past(tick_i));

    a_r7_commit_to_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.out != $past(st_q.out)) |-> (st_q.out == $past(sync_w)));

    a_r6_count_needs_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != '0) |-> (($past(sync_w) != $past(st_q.out))
                              && ($past(sync_w) == $past(st_q.last))));

    a_r2_bypass_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!cfg.enable) |-> (st_q.out == $past(sync_w)));
endmodule

// File: rtl/pow2_debounce.sv
module pow2_debounce
    import dbf_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int CLKS_PER_MS = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [LANES*FIELD_W-1:0] cfg_i,
    input  logic [LANES-1:0]         raw_i,
    output logic [LANES-1:0]         filt_o
);
    logic tick_w;

    dbf_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dbf_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_w),
            .field_i (cfg_i[g*FIELD_W +: FIELD_W]),
            .raw_i   (raw_i[g]),
            .filt_o  (filt_o[g])
        );
    end

    a_r8_reset_low: assert property (@(posedge clk_i)
        !rst_ni |-> (filt_o == '0));
endmodule

// File: tb/tb_pow2_debounce.sv
`timescale 1ns/100ps
module tb_pow2_debounce;
    localparam int P = 4;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = '0;
    logic [1:0] raw = '0;
    logic [1:0] filt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic cur0, cur1;

    always #2.5 clk = ~clk;

    pow2_debounce #(.LANES(2), .CLKS_PER_MS(P), .SYNC_STAGES(S)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .raw_i(raw), .filt_o(filt)
    );

    function automatic int lo_edges(int n);
        return S + 1 + ((1 << n) - 1) * P;
    endfunction

    function automatic int hi_edges(int n);
        return S + 1 + (1 << n) * P;
    endfunction

    function automatic logic [3:0] fld(logic en, int n);
        return {en, 3'(n)};
    endfunction

    task automatic chk(input string tag, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    // lane 0 level change with window checks
    task automatic step0(input int n, input logic v, input string tag);
        @(negedge clk) raw[0] = v;
        repeat (lo_edges(n)) @(posedge clk);
        #1 chk({tag, " R4 early"}, filt[0], cur0);
        repeat (hi_edges(n) - lo_edges(n)) @(posedge clk);
        #1 chk({tag, " R3 late"}, filt[0], v);
        cur0 = v;
    endtask

    task automatic pulse0(input int len);
        @(negedge clk) raw[0] = ~cur0;
        repeat (len) @(negedge clk);
        raw[0] = cur0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        raw = 2'b10;
        cfg = {fld(1'b1, 7), fld(1'b1, 3)};
        repeat (3) @(posedge clk);
        #1 chk("R8 reset lane0", filt[0], 1'b0);
        chk("R8 reset lane1", filt[1], 1'b0);
        @(negedge clk) rst_n = 1'b1;
        cur0 = 1'b0; cur1 = 1'b1;
        repeat (S + 2) @(posedge clk);
        #1 chk("R8 load lane0", filt[0], 1'b0);
        chk("R8 load lane1 no wait", filt[1], 1'b1);

        // R2 bypass on lane 1
        @(negedge clk) cfg[7:4] = fld(1'b0, 7);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) raw[1] = ~cur1;
            @(posedge clk); #1 chk("R2 bypass not early", filt[1], cur1);
            @(posedge clk); #1 chk("R2 bypass delay", filt[1], ~cur1);
            cur1 = ~cur1;
            chk("R9 lane0 untouched", filt[0], cur0);
        end

        // R10 / R1 boundaries on lane 0
        @(negedge clk) cfg[3:0] = fld(1'b1, 0);
        step0(0, 1'b1, "R10 n0 R1");
        step0(0, 1'b0, "R10 n0 R1");
        @(negedge clk) cfg[3:0] = fld(1'b1, 7);
        step0(7, 1'b1, "R10 n7 R1");
        chk("R9 lane1 untouched", filt[1], cur1);

        // R5 glitches at n=2
        @(negedge clk) cfg[3:0] = fld(1'b1, 2);
        pulse0(((1 << 2) - 1) * P);
        repeat (hi_edges(2) + 2) @(posedge clk);
        #1 chk("R5 max glitch rejected", filt[0], cur0);
        pulse0(1);
        repeat (hi_edges(2) + 2) @(posedge clk);
        #1 chk("R5 short glitch rejected", filt[0], cur0);

        // R6 restart train
        for (int k = 0; k < 5; k++) pulse0(((1 << 2) - 1) * P);
        repeat (hi_edges(2) + 2) @(posedge clk);
        #1 chk("R6 train never commits", filt[0], cur0);
        step0(2, ~cur0, "R6 after train");

        // random mix
        for (int it = 0; it < 30; it++) begin
            int n = $urandom_range(0, 3);
            @(negedge clk) cfg[3:0] = fld(1'b1, n);
            if (n > 0) begin
                int g = $urandom_range(0, 3);
                for (int k = 0; k < g; k++) begin
                    pulse0($urandom_range(1, ((1 << n) - 1) * P));
                    repeat ($urandom_range(1, 3)) @(negedge clk);
                end
                if (g > 0) begin
                    repeat (hi_edges(n)) @(posedge clk);
                    #1 chk("R5 rand glitches", filt[0], cur0);
                end
            end
            step0(n, ~cur0, "R7 rand");
        end
        chk("R9 lane1 final", filt[1], cur1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule